// File: doc/BRIEF.md
# One-Shot / Periodic Down-Counting Timer Channel

This block is one timer channel. It counts down on an external tick-enable strobe, for example a 1 MHz tick derived from the system clock. Software programs it through a small register port with two word registers.

The trigger register packs three fields:
- an enable bit,
- a mode bit that selects periodic or one-shot operation,
- a 29-bit load value.

A load of n makes the channel expire on the (n+1)th counted tick, so a load of zero expires on the very next tick. In one-shot mode the channel turns itself off on expiry. In periodic mode it reloads the programmed value and keeps running.

Every expiry sets a level interrupt that stays high until software clears it. Software clears it by writing a one to bit 30 of the status register. A read of the status register returns the pending flag and the live count.

The register port is a single-cycle write strobe with a shared address, and a combinational read of the addressed word. Address bit 2 selects the register: offset 0x0 is the trigger register and offset 0x4 is the status register. Address bits 1:0 are ignored. This keeps the channel at an 8-byte stride when it is replicated. The reset input is asynchronous and active-low, and its release is expected to be synchronous to `clk`.

Top module: `tmr_channel`

## Requirements
- R1: After reset, both registers read 0 and `irq` is low.
- R2: A write to offset 0x0 stores bit 31 as enable, bit 30 as periodic mode (1 = periodic) and bits 28:0 as the load value, and also copies the load value into the count. A read of offset 0x0 returns enable at bit 31, mode at bit 30 and the load value at bits 28:0. Bit 29 always reads 0.
- R3: While enabled, the count drops by one on each clock in which `tick_en` is high, and holds when `tick_en` is low. A load of n expires on the (n+1)th tick and sets `irq` one clock after that tick.
- R4: In one-shot mode, expiry clears the enable bit. The count then stays at 0 under further ticks.
- R5: In periodic mode, expiry reloads the load value into the count and the enable bit stays set, so the channel expires every n+1 ticks.
- R6: A disabled channel ignores ticks and keeps its count. Writing 0 to offset 0x0 stops the channel with a count of 0.
- R7: A write to offset 0x0 while the channel is running restarts the count from the newly written value.
- R8: `irq` is a level that stays high, even after the channel is disabled, until a write to offset 0x4 with bit 30 set. A write to offset 0x4 with bit 30 clear has no effect.
- R9: A read of offset 0x4 returns the pending flag at bit 30 and the current count at bits 28:0. All other bits read 0.
- R10: When an expiry and a clearing write happen in the same clock, the interrupt stays set.
- R11: When a write to offset 0x0 and a tick happen in the same clock, the write wins and that tick is not counted.
- R12: The largest load value, 0x1FFFFFFF, is accepted in full and counts down from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Byte offset; bit 2 selects the register |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Combinational read of the addressed register |
| irq | output | 1 | Sticky level interrupt |

## Verification
Writes, ticks and clears all take effect on the clock edge on which they are presented. Their results are therefore due one clock later, on both `irq` and the register reads. The read path adds no cycle, because `rd_data` follows `addr` within the same clock.

The bench drives each stimulus at a falling edge and lets one rising edge pass. It then reads both registers and `irq` at the next falling edge, so each check lands exactly on the cycle its result is due. The directed cases count ticks one by one to pin the n+1 expiry point. Random cycles are then compared against a model of the requirements, cycle by cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control bit positions shared by the trigger and status registers.
  localparam int EN_BIT  = 31;
  localparam int PER_BIT = 30;
  localparam int CLR_BIT = 30;  // write-1-to-clear / pending flag position
  localparam int SEL_BIT = 2;   // address bit selecting the register

  typedef enum logic {
    REG_TRIG = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ld_we,
  input  logic             ld_en,
  input  logic             ld_per,
  input  logic [CNT_W-1:0] ld_val,
  output logic             en_q,
  output logic             per_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic             en_d, per_d;
  logic [CNT_W-1:0] load_d, cnt_d;
  logic             upd;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = en_q && tick_en && at_zero && !ld_we;
  assign upd     = ld_we || (en_q && tick_en);

  always_comb begin
    en_d   = en_q;
    per_d  = per_q;
    load_d = load_q;
    cnt_d  = cnt_q;
    if (ld_we) begin
      en_d   = ld_en;
      per_d  = ld_per;
      load_d = ld_val;
      cnt_d  = ld_val;
    end else if (en_q && tick_en) begin
      if (at_zero) begin
        if (per_q) cnt_d = load_q;
        else       en_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      en_q   <= en_d;
      per_q  <= per_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;
  logic upd;

  assign upd = set || clr;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;  // a new event outranks a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  reg_sel_e         sel;
  logic             trig_wr, clr_wr;
  logic             en_q, per_q, expire;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             unused_bits;

  assign sel         = reg_sel_e'(addr[SEL_BIT]);
  assign trig_wr     = wr_en && (sel == REG_TRIG);
  assign clr_wr      = wr_en && (sel == REG_STAT) && wr_data[CLR_BIT];
  assign unused_bits = ^{addr, wr_data};

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .ld_we   (trig_wr),
    .ld_en   (wr_data[EN_BIT]),
    .ld_per  (wr_data[PER_BIT]),
    .ld_val  (wr_data[CNT_W-1:0]),
    .en_q    (en_q),
    .per_q   (per_q),
    .load_q  (load_q),
    .cnt_q   (cnt_q),
    .expire  (expire)
  );

  tmr_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (expire),
    .clr    (clr_wr),
    .flag_q (irq)
  );

  always_comb begin
    rd_data = '0;
    if (sel == REG_TRIG) begin
      rd_data[EN_BIT]    = en_q;
      rd_data[PER_BIT]   = per_q;
      rd_data[CNT_W-1:0] = load_q;
    end else begin
      rd_data[CLR_BIT]   = irq;
      rd_data[CNT_W-1:0] = cnt_q;
    end
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              trig_wr,
  input logic              clr_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic              en_q,
  input logic              per_q,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              irq
);
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_en && cnt_q != '0 && !trig_wr) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !per_q && tick_en && cnt_q == '0 && !trig_wr) |=> (!en_q && cnt_q == '0));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && per_q && tick_en && cnt_q == '0 && !trig_wr) |=> (en_q && cnt_q == $past(load_q)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !trig_wr) |=> (!en_q && $stable(cnt_q)));

  p_write_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> (cnt_q == $past(wr_data[CNT_W-1:0]) && en_q == $past(wr_data[EN_BIT])));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_en && cnt_q == '0 && !trig_wr) |=> irq);
endmodule

bind tmr_channel tmr_channel_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .trig_wr (trig_wr),
  .clr_wr  (clr_wr),
  .wr_data (wr_data),
  .en_q    (en_q),
  .per_q   (per_q),
  .load_q  (load_q),
  .cnt_q   (cnt_q),
  .irq     (irq)
);

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // reference model state, built from the requirements
  bit        m_en, m_per, m_irq;
  bit [28:0] m_load, m_cnt;

  always #4 clk = ~clk;  // 125 MHz

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic void model_step(bit tk, bit we, logic [2:0] a, logic [31:0] d);
    bit exp_now = 1'b0;
    if (we && !a[2]) begin
      m_en = d[31]; m_per = d[30]; m_load = d[28:0]; m_cnt = d[28:0];
    end else if (tk && m_en) begin
      if (m_cnt == 0) begin
        exp_now = 1'b1;
        if (m_per) m_cnt = m_load;
        else       m_en = 1'b0;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    if (we && a[2] && d[30]) m_irq = 1'b0;
    if (exp_now) m_irq = 1'b1;
  endfunction

  task automatic cyc(input bit tk, input bit we, input logic [2:0] a, input logic [31:0] d);
    tick_en = tk; wr_en = we; addr = a; wr_data = d;
    @(posedge clk);
    model_step(tk, we, a, d);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic chk_regs(input string tag, input logic [31:0] e0, input logic [31:0] e4);
    logic [31:0] v;
    rd(3'd0, v); chk({tag, " trig"}, v, e0);
    rd(3'd4, v); chk({tag, " stat"}, v, e4);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v, v0, v4;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    {m_en, m_per, m_irq, m_load, m_cnt} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_regs("R1 reset", 32'h0, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 field packing, bit 29 dropped
    wr(3'd0, 32'hA000_0005);
    chk_regs("R2 readback", 32'h8000_0005, 32'h0000_0005);

    // R3 n+1 expiry, R4 one-shot stop
    wr(3'd0, 32'h8000_0003);
    tick(3);
    chk_regs("R3 before expiry", 32'h8000_0003, 32'h0);
    chk("R3 irq low at count 0", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R3 irq on tick n+1", {31'd0, irq}, 32'd1);
    chk_regs("R4 one-shot off R9", 32'h0000_0003, 32'h4000_0000);
    tick(2);
    chk_regs("R4 stays at zero", 32'h0000_0003, 32'h4000_0000);

    // R8 sticky and write-1-to-clear
    wr(3'd4, 32'hBFFF_FFFF);
    chk("R8 clear bit zero ignored", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h4000_0000);
    chk("R8 cleared", {31'd0, irq}, 32'd0);
    chk_regs("R8 status after clear", 32'h0000_0003, 32'h0);

    // R3 no count without tick
    wr(3'd0, 32'h8000_0004);
    repeat (5) cyc(1'b0, 1'b0, 3'd0, 32'd0);
    chk_regs("R3 hold without tick", 32'h8000_0004, 32'h4);

    // R5 periodic reload
    wr(3'd0, 32'hC000_0002);
    tick(3);
    chk_regs("R5 reload R9", 32'hC000_0002, 32'h4000_0002);
    wr(3'd4, 32'h4000_0000);
    tick(2);
    chk_regs("R5 second period", 32'hC000_0002, 32'h0);
    tick(1);
    chk("R5 second expiry", {31'd0, irq}, 32'd1);

    // R10 set beats clear
    wr(3'd0, 32'hC000_0000);
    wr(3'd4, 32'h4000_0000);
    chk("R10 pre-clear", {31'd0, irq}, 32'd0);
    cyc(1'b1, 1'b1, 3'd4, 32'h4000_0000);
    chk("R10 set wins", {31'd0, irq}, 32'd1);

    // R6 stop and disabled hold; R8 irq survives disable
    wr(3'd0, 32'h0);
    tick(4);
    chk_regs("R6 stopped R8", 32'h0, 32'h4000_0000);
    wr(3'd4, 32'h4000_0000);
    wr(3'd0, 32'h0000_0005);
    tick(3);
    chk_regs("R6 disabled ignores ticks", 32'h5, 32'h5);
    chk("R6 no irq", {31'd0, irq}, 32'd0);

    // R7 restart while running
    wr(3'd0, 32'h8000_0010);
    tick(4);
    chk_regs("R7 running", 32'h8000_0010, 32'hC);
    wr(3'd0, 32'h8000_0007);
    chk_regs("R7 restart", 32'h8000_0007, 32'h7);
    tick(1);
    chk_regs("R7 counts new value", 32'h8000_0007, 32'h6);

    // R11 write beats tick
    cyc(1'b1, 1'b1, 3'd0, 32'h8000_0009);
    chk_regs("R11 write wins", 32'h8000_0009, 32'h9);

    // R12 full-width load
    wr(3'd0, 32'h9FFF_FFFF);
    chk_regs("R12 max load", 32'h9FFF_FFFF, 32'h1FFF_FFFF);
    tick(1);
    chk_regs("R12 decrement", 32'h9FFF_FFFF, 32'h1FFF_FFFE);

    // random phase against the model (R2..R11)
    for (int i = 0; i < 3000; i++) begin
      bit          tk, we;
      logic [2:0]  a;
      logic [31:0] d, r;
      r  = $urandom;
      tk = r[0];
      we = (r[3:1] == 3'd0);
      a  = r[6:4];
      d  = {r[8:7], 27'd0, r[11:9]};
      cyc(tk, we, a, d);
      rd(3'd0, v0);
      rd(3'd4, v4);
      chk("R2 random trig", v0, {m_en, m_per, 1'b0, m_load});
      chk("R9 random stat", v4, {1'b0, m_irq, 1'b0, m_cnt});
      chk("R8 random irq", {31'd0, irq}, {31'd0, m_irq});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule